// File: doc/BRIEF.md
# Bit-Serial Scalar Product Unit

This block computes the dot product of two vectors of signed two's complement elements as one combined operation. No multiplier is used, and no per-pair product is ever completed or stored. The unit scans the multiplier digits of all elements together, one bit per step, starting at the least significant bit. In each step every element pair picks either its multiplicand or zero. The sum of those picks across the whole vector is added to a running result, which then shifts right by one bit.

Bits that leave the low end of the running result are kept in a low-order register, so the final value has full precision. The step for the multiplier sign bit subtracts the sum, by inverting it and adding one. The caller loads both vectors with a one-cycle start pulse. Exactly `W` cycles later a one-cycle done pulse marks a valid result, and the result stays on the output until the next accepted start.

Top module: `dotp_serial`

## Requirements
- R1: With elements packed as element i at bits [i*W +: W] of each vector input, the signed result equals the sum over i of a_i times b_i, where each element is a W-bit two's complement value.
- R2: A start seen while idle loads both vectors. Done is high for exactly one cycle, in the W-th cycle after the loading clock edge.
- R3: A start raised while a computation runs is ignored, together with any operand change at that time. The result that follows belongs to the vectors loaded first.
- R4: After done, the result output holds its value until the next accepted start.
- R5: When every element of both vectors is the most negative value, the result is N*2^(2W-2), with no overflow in RW = 2W + ceil(log2 N) bits.
- R6: All-zero vectors, or a zero vector paired with any other vector, give a result of zero.
- R7: After reset, done is low, the result is zero and the unit accepts a start.
- R8: Mixed signs come out correctly, including multipliers of -1 and multiplicands of opposite sign. This exercises the subtracted sign-bit step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the vectors and begin, when idle |
| vec_a | input | N*W | Multiplicand vector, element i at [i*W +: W] |
| vec_b | input | N*W | Multiplier vector, element i at [i*W +: W] |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | RW | Signed full-precision scalar product |

## Verification
Every cycle, the assertions check the handshake: an accepted start leads to busy, busy continues until the last step, done lasts a single cycle, and the result stays frozen while the unit is idle without a start. The value of the result cannot be seen by any property. Only the bench scenarios show it: random vectors checked against a reference sum of products, all operands at the most negative value, zero vectors, mixed signs, and a start injected mid-run, each with the latency counted at the ports.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dotp_state_e;
endpackage

// File: rtl/dotp_pp_sum.sv
// Forms one partial product per element pair from the current multiplier
// bit (multiplicand or zero) and adds them into one macro-partial product.
module dotp_pp_sum #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int SW = W + $clog2(N)
) (
  input  logic [N*W-1:0] mcand,
  input  logic [N-1:0]   mbit,
  output logic [SW-1:0]  macro
);
  logic [SW-1:0] pp [N];

  for (genvar i = 0; i < N; i++) begin : g_pp
    logic [W-1:0] elem;
    assign elem  = mcand[i*W +: W];
    assign pp[i] = mbit[i] ? {{(SW-W){elem[W-1]}}, elem} : '0;
  end

  always_comb begin
    macro = '0;
    for (int i = 0; i < N; i++) begin
      macro = macro + pp[i];
    end
  end
endmodule

// File: rtl/dotp_accum.sv
// Running result: high part takes the macro-partial product (added, or
// subtracted on the sign step), then shifts right into the low register.
module dotp_accum #(
  parameter int W  = 8,
  parameter int SW = W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          neg,
  input  logic [SW-1:0] macro,
  output logic [SW-1:0] hi_q,
  output logic [W-1:0]  lo_q
);
  logic [SW:0]   addend;
  logic [SW:0]   sum_t;
  logic [SW-1:0] hi_d;
  logic [W-1:0]  lo_d;

  always_comb begin
    addend = {macro[SW-1], macro};
    if (neg) addend = ~addend;
    sum_t = {hi_q[SW-1], hi_q} + addend + {{SW{1'b0}}, neg};
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (clr) begin
      hi_d = '0;
      lo_d = '0;
    end else if (step) begin
      hi_d = sum_t[SW:1];
      lo_d = {sum_t[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (clr || step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R7 (clear on load): a load leaves the running result at zero
  a_r7_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hi_q == '0 && lo_q == '0));
endmodule

// File: rtl/dotp_ctrl.sv
// Step sequencer: idle until start, W steps, one-cycle done.
module dotp_ctrl
  import dotp_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  dotp_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;

  assign busy = (state_q == ST_RUN);
  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (busy) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
    end
  end

  a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt_q == '0));
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last));
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/dotp_serial.sv
module dotp_serial #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int SW = W + $clog2(N),
  parameter int RW = SW + W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N*W-1:0] vec_a,
  input  logic [N*W-1:0] vec_b,
  output logic          done,
  output logic [RW-1:0] result
);
  logic          load, step, last, busy;
  logic [N*W-1:0] a_q;
  logic [W-1:0]  b_q [N];
  logic [N-1:0]  mbit;
  logic [SW-1:0] macro;
  logic [SW-1:0] hi_q;
  logic [W-1:0]  lo_q;

  dotp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .last(last), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (load) a_q <= vec_a;
  end

  for (genvar i = 0; i < N; i++) begin : g_mul
    logic [W-1:0] b_d;
    always_comb begin
      b_d = b_q[i];
      if (load)      b_d = vec_b[i*W +: W];
      else if (step) b_d = {1'b0, b_q[i][W-1:1]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             b_q[i] <= '0;
      else if (load || step)  b_q[i] <= b_d;
    end
    assign mbit[i] = b_q[i][0];
  end

  dotp_pp_sum #(.W(W), .N(N), .SW(SW)) u_pp (
    .mcand(a_q), .mbit(mbit), .macro(macro)
  );

  dotp_accum #(.W(W), .SW(SW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(load), .step(step), .neg(last),
    .macro(macro), .hi_q(hi_q), .lo_q(lo_q)
  );

  assign result = {hi_q, lo_q};

  a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

// File: tb/dotp_serial_test.sv
`timescale 1ns/1ps
module dotp_serial_test;
  localparam int W  = 8;
  localparam int N  = 4;
  localparam int SW = W + $clog2(N);
  localparam int RW = SW + W;

  logic           clk, rst_n, start, done;
  logic [N*W-1:0] vec_a, vec_b;
  logic [RW-1:0]  result;
  int tests, fails;
  bit finished;

  dotp_serial #(.W(W), .N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vec_a(vec_a), .vec_b(vec_b), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic longint ref_dot(input logic [N*W-1:0] a, input logic [N*W-1:0] b);
    longint s = 0;
    for (int i = 0; i < N; i++) begin
      logic signed [W-1:0] ea, eb;
      ea = a[i*W +: W];
      eb = b[i*W +: W];
      s += longint'(ea) * longint'(eb);
    end
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint res_s();
    logic signed [RW-1:0] r;
    r = result;
    return longint'(r);
  endfunction

  task automatic run(input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                     input string req, input bit poke);
    int lat;
    longint held;
    @(negedge clk);
    vec_a = a; vec_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      if (poke && lat == 2) begin
        vec_a = ~a; vec_b = ~b; start = 1'b1;   // R3: must be ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({req, " R2 latency"}, lat, W);
    check(req, res_s(), ref_dot(a, b));
    held = res_s();
    @(negedge clk);
    check("R2 done one cycle", done, 0);
    @(negedge clk);
    check("R4 result held", res_s(), held);
  endtask

  initial begin
    finished = 1'b0;
    #(5.0 * 100000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] ra, rb;
    int unsigned seed;
    tests = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; vec_a = '0; vec_b = '0;
    seed = 32'd20240517;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R7 done after reset", done, 0);
    check("R7 result after reset", res_s(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle holds", done, 0);

    run({N{8'h80}}, {N{8'h80}}, "R5 all most-negative", 1'b0);
    check("R5 value", res_s(), longint'(N) <<< (2*W-2));
    run('0, '0, "R6 all zero", 1'b0);
    run({N{8'h7f}}, '0, "R6 zero multiplier", 1'b0);
    run('0, {N{8'h81}}, "R6 zero multiplicand", 1'b0);
    run({8'h7f, 8'h80, 8'h05, 8'hfd}, {N{8'hff}}, "R8 times minus one", 1'b0);
    run({8'h80, 8'h7f, 8'h80, 8'h7f}, {8'h7f, 8'h80, 8'h80, 8'h7f}, "R8 mixed signs", 1'b0);
    run({N{8'h7f}}, {N{8'h7f}}, "R1 max positive", 1'b0);
    run({8'h12, 8'h34, 8'hc5, 8'h9a}, {8'h77, 8'h81, 8'h3c, 8'he0}, "R3 start while busy", 1'b1);

    for (int k = 0; k < 40; k++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      run(ra, rb, "R1 random", (k % 7) == 3);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule